// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Decoder

This block is a cycle-based model of the command side of a byte-wide NOR flash with 17 address bits and 8 data bits. A host presents an address and a data byte together with a one-cycle write strobe. The decoder watches these writes for unlock-prefixed command sequences and turns them into byte programs, whole-array erases, single-sector erases, entry into and exit from an identification read mode, and a one-way lock that write-protects the boot sector. Writes that do not form a valid sequence return the decoder to idle and change nothing.

Program and erase operations run for a fixed number of clock cycles, set by parameters. While one runs, every read returns a polling byte whose bit 7 is the inverse of the final value, so a host can spin on bit 7 until it matches. The sector map, with the boot sector at either the bottom or the top of the address space, is picked by a parameter. To keep the model small, each sector stores a window of `2^WIN_AW` bytes addressed by the low address bits; higher in-sector bits alias onto that window.

Reads are combinational from the address port: polling status while busy, identification bytes in identification mode, and the stored byte otherwise.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the block is idle, not in identification mode, not locked, and every stored byte reads as 8'hFF.
- R2: The writes AA at 5555, 55 at 2AAA, A0 at 5555, then any address with data D, program that byte to (old AND D); only address bits 14:0 are compared against the unlock addresses 5555 and 2AAA.
- R3: For exactly PROG_CYC cycles after the last program write (ERASE_CYC after the last erase write) every read returns bits 6:0 as zero and bit 7 as the inverse of bit 7 of the programmed data, or 0 during an erase; afterwards reads return array data again.
- R4: The writes AA at 5555, 55 at 2AAA, 80 at 5555, AA at 5555, 55 at 2AAA, 10 at 5555 erase every sector to 8'hFF, except the boot sector while locked.
- R5: The same five-write prefix followed by 30 at any address erases only the sector that contains that address.
- R6: With TOP_BOOT=0 the sectors are boot 00000-03FFF, parameter 04000-05FFF and 06000-07FFF, main 08000-0FFFF and 10000-1FFFF; with TOP_BOOT=1 they are boot 1C000-1FFFF, parameter 1A000-1BFFF and 18000-19FFF, main 10000-17FFF and 00000-0FFFF.
- R7: AA at 5555, 55 at 2AAA, 90 at 5555 enter identification mode, in which reads with address bits 1:0 equal to 0, 1, 2 return MFR_ID, DEV_ID and {7'b0, lock flag}; data F0 written to any address (except as program data) leaves the mode.
- R8: The erase prefix followed by 40 at 5555 sets the lock flag, which only reset clears; while set, programs and sector erases aimed at the boot sector are dropped without a busy period, and other sectors behave normally.
- R9: A write that does not match the next expected step returns the decoder to idle, so the later steps of that sequence have no effect.
- R10: Writes that arrive while an operation is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | 17 | Byte address for writes and reads |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data: polling byte, identification byte or stored byte |

## Verification
The bench builds two instances with PROG_CYC=5, ERASE_CYC=12 and WIN_AW=3, one with the bottom boot map and one with the top boot map, and sets its own identification bytes. The short operation lengths let it count the busy window cycle by cycle and see the polling byte flip exactly at the end. The three-bit window gives each sector eight distinct bytes, enough to show that erasing one sector leaves its neighbours intact and that locking protects only the boot sector in both maps.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int ADDR_W      = 17;
  localparam int NUM_SECTORS = 5;

  typedef enum logic [2:0] {
    SEC_BOOT   = 3'd0,
    SEC_PNEAR  = 3'd1,
    SEC_PFAR   = 3'd2,
    SEC_MAIN_S = 3'd3,
    SEC_MAIN_L = 3'd4
  } sector_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_SECT = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_U1   = 3'd1,
    ST_U2   = 3'd2,
    ST_PGM  = 3'd3,
    ST_E1   = 3'd4,
    ST_E2   = 3'd5,
    ST_E3   = 3'd6
  } seq_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_LOCK  = 8'h40;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;

  // The top-boot map is the bottom-boot map seen through inverted address bits.
  function automatic sector_e decode_sector(input logic [ADDR_W-1:0] a, input logic top);
    logic [ADDR_W-1:0] b;
    b = top ? ~a : a;
    if (b[16])       return SEC_MAIN_L;
    else if (b[15])  return SEC_MAIN_S;
    else if (!b[14]) return SEC_BOOT;
    else if (!b[13]) return SEC_PNEAR;
    else             return SEC_PFAR;
  endfunction

  // Flash cells only move from 1 to 0 when programmed.
  function automatic logic [7:0] program_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] poll_byte(input op_e kind, input logic [7:0] d);
    return {(kind == OP_PROG) ? ~d[7] : 1'b0, 7'b0};
  endfunction

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output sector_e           sec,
  output logic              is_boot
);

  generate
    if (TOP_BOOT) begin : g_top
      assign sec = decode_sector(addr, 1'b1);
    end else begin : g_bottom
      assign sec = decode_sector(addr, 1'b0);
    end
  endgenerate

  assign is_boot = (sec == SEC_BOOT);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [14:0] ua,
  input  logic [7:0]  wd,
  input  logic        busy,
  input  logic        wr_boot,
  output logic        start,
  output op_e         start_kind,
  output logic        id_mode,
  output logic        locked
);

  seq_e st_q, st_d;
  logic id_q, id_d;
  logic lk_q, lk_d;
  logic accept, is_a, is_b, boot_blocked;

  assign accept       = we && !busy;
  assign is_a         = (ua == UNLOCK_A);
  assign is_b         = (ua == UNLOCK_B);
  assign boot_blocked = wr_boot && lk_q;

  always_comb begin
    st_d       = st_q;
    id_d       = id_q;
    lk_d       = lk_q;
    start      = 1'b0;
    start_kind = OP_NONE;
    if (accept) begin
      st_d = ST_IDLE;
      if (st_q != ST_PGM && wd == CMD_EXIT) id_d = 1'b0;
      case (st_q)
        ST_IDLE: if (is_a && wd == CMD_KEY1) st_d = ST_U1;
        ST_U1:   if (is_b && wd == CMD_KEY2) st_d = ST_U2;
        ST_U2: begin
          if (is_a) begin
            if (wd == CMD_PROG)       st_d = ST_PGM;
            else if (wd == CMD_ID)    id_d = 1'b1;
            else if (wd == CMD_ERASE) st_d = ST_E1;
          end
        end
        ST_PGM: begin
          if (!boot_blocked) begin
            start      = 1'b1;
            start_kind = OP_PROG;
          end
        end
        ST_E1:   if (is_a && wd == CMD_KEY1) st_d = ST_E2;
        ST_E2:   if (is_b && wd == CMD_KEY2) st_d = ST_E3;
        ST_E3: begin
          if (is_a && wd == CMD_CHIP) begin
            start      = 1'b1;
            start_kind = OP_CHIP;
          end else if (wd == CMD_SECT) begin
            if (!boot_blocked) begin
              start      = 1'b1;
              start_kind = OP_SECT;
            end
          end else if (is_a && wd == CMD_LOCK) begin
            lk_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      id_q <= 1'b0;
      lk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      id_q <= id_d;
      lk_q <= lk_d;
    end
  end

  assign id_mode = id_q;
  assign locked  = lk_q;

  assert_lock_oneway_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st_q));

  assert_id_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !busy && wd == CMD_EXIT && st_q != ST_PGM) |=> !id_mode);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 200,
  parameter int WIN_AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               kind,
  input  logic [WIN_AW-1:0] off,
  input  logic [7:0]        data,
  input  sector_e           sec,
  output logic              busy,
  output logic              done,
  output op_e               cur_kind,
  output logic [WIN_AW-1:0] cur_off,
  output logic [7:0]        cur_data,
  output sector_e           cur_sec
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] load_count(input op_e k);
    return (k == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      cur_kind <= OP_NONE;
      cur_off  <= '0;
      cur_data <= 8'hFF;
      cur_sec  <= SEC_BOOT;
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= load_count(kind);
      cur_kind <= kind;
      cur_off  <= off;
      cur_data <= data;
      cur_sec  <= sec;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);

  assert_start_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  assert_busy_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_cmd_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sector_e           rd_sec,
  input  logic [WIN_AW-1:0] rd_off,
  input  logic              commit,
  input  op_e               kind,
  input  sector_e           sec,
  input  logic [WIN_AW-1:0] off,
  input  logic [7:0]        data,
  input  logic              locked,
  output logic [7:0]        rd_byte
);

  localparam int WIN = 1 << WIN_AW;

  logic [7:0] sec_rd [NUM_SECTORS];

  generate
    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
      logic [7:0] row_q [WIN];
      logic       hit, clr, pgm;

      assign hit = (sec == sector_e'(s));
      assign clr = commit && (((kind == OP_CHIP) && !((sector_e'(s) == SEC_BOOT) && locked)) ||
                              ((kind == OP_SECT) && hit));
      assign pgm = commit && (kind == OP_PROG) && hit;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int w = 0; w < WIN; w++) row_q[w] <= 8'hFF;
        end else if (clr) begin
          for (int w = 0; w < WIN; w++) row_q[w] <= 8'hFF;
        end else if (pgm) begin
          row_q[off] <= program_merge(row_q[off], data);
        end
      end

      assign sec_rd[s] = row_q[rd_off];

      assert_prog_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm |=> ((row_q[$past(off)] & ~$past(row_q[off])) == 8'h00));

      assert_erase_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (row_q[0] == 8'hFF));
    end
  endgenerate

  assign rd_byte = sec_rd[rd_sec];

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter bit         TOP_BOOT  = 1'b0,
  parameter int         WIN_AW    = 6,
  parameter int         PROG_CYC  = 20,
  parameter int         ERASE_CYC = 200,
  parameter logic [7:0] MFR_ID    = 8'hC5,
  parameter logic [7:0] DEV_ID    = 8'h3A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [16:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata
);

  sector_e           addr_sec;
  logic              addr_boot;
  logic              start, busy, done, id_mode, locked;
  op_e               start_kind, cur_kind;
  logic [WIN_AW-1:0] cur_off;
  logic [7:0]        cur_data, arr_byte;
  sector_e           cur_sec;

  flash_sector_map #(.TOP_BOOT(TOP_BOOT)) u_map (
    .addr    (addr),
    .sec     (addr_sec),
    .is_boot (addr_boot)
  );

  flash_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .ua         (addr[14:0]),
    .wd         (wdata),
    .busy       (busy),
    .wr_boot    (addr_boot),
    .start      (start),
    .start_kind (start_kind),
    .id_mode    (id_mode),
    .locked     (locked)
  );

  flash_op_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .WIN_AW    (WIN_AW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (start_kind),
    .off      (addr[WIN_AW-1:0]),
    .data     (wdata),
    .sec      (addr_sec),
    .busy     (busy),
    .done     (done),
    .cur_kind (cur_kind),
    .cur_off  (cur_off),
    .cur_data (cur_data),
    .cur_sec  (cur_sec)
  );

  flash_store #(.WIN_AW(WIN_AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sec  (addr_sec),
    .rd_off  (addr[WIN_AW-1:0]),
    .commit  (done),
    .kind    (cur_kind),
    .sec     (cur_sec),
    .off     (cur_off),
    .data    (cur_data),
    .locked  (locked),
    .rd_byte (arr_byte)
  );

  always_comb begin
    if (busy) begin
      rdata = poll_byte(cur_kind, cur_data);
    end else if (id_mode) begin
      case (addr[1:0])
        2'd0:    rdata = MFR_ID;
        2'd1:    rdata = DEV_ID;
        2'd2:    rdata = {7'b0, locked};
        default: rdata = 8'h00;
      endcase
    end else begin
      rdata = arr_byte;
    end
  end

  assert_boot_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && locked && start_kind != OP_CHIP) |-> !addr_boot);

  assert_poll_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rdata[6:0] == 7'b0));

endmodule

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;

  localparam int PC = 5;
  localparam int EC = 12;
  localparam logic [7:0] MID = 8'hB7;
  localparam logic [7:0] DID = 8'h4E;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [16:0] a0 = '0, a1 = '0;
  logic [7:0]  d0 = '0, d1 = '0;
  logic [7:0]  q0, q1;
  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  flash_cmd_top #(.TOP_BOOT(1'b0), .WIN_AW(3), .PROG_CYC(PC), .ERASE_CYC(EC),
                  .MFR_ID(MID), .DEV_ID(DID)) dut (
    .clk(clk), .rst_n(rst_n), .we(we0), .addr(a0), .wdata(d0), .rdata(q0));

  flash_cmd_top #(.TOP_BOOT(1'b1), .WIN_AW(3), .PROG_CYC(PC), .ERASE_CYC(EC),
                  .MFR_ID(MID), .DEV_ID(DID)) dut_t (
    .clk(clk), .rst_n(rst_n), .we(we1), .addr(a1), .wdata(d1), .rdata(q1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input bit t, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    if (t) begin we1 = 1'b1; a1 = a; d1 = d; end
    else   begin we0 = 1'b1; a0 = a; d0 = d; end
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic rchk(input bit t, input logic [16:0] a, input logic [7:0] exp, input string req);
    if (t) a1 = a; else a0 = a;
    #2;
    chk(req, t ? q1 : q0, exp);
  endtask

  task automatic pfx(input bit t);
    wr(t, 17'h05555, 8'hAA);
    wr(t, 17'h02AAA, 8'h55);
  endtask

  task automatic prog_go(input bit t, input logic [16:0] a, input logic [7:0] d);
    pfx(t);
    wr(t, 17'h05555, 8'hA0);
    wr(t, a, d);
  endtask

  task automatic prog(input bit t, input logic [16:0] a, input logic [7:0] d);
    prog_go(t, a, d);
    repeat (PC + 1) @(negedge clk);
  endtask

  task automatic erase_pfx(input bit t);
    pfx(t);
    wr(t, 17'h05555, 8'h80);
    pfx(t);
  endtask

  task automatic chip(input bit t);
    erase_pfx(t);
    wr(t, 17'h05555, 8'h10);
    repeat (EC + 1) @(negedge clk);
  endtask

  task automatic sect(input bit t, input logic [16:0] a);
    erase_pfx(t);
    wr(t, a, 8'h30);
    repeat (EC + 1) @(negedge clk);
  endtask

  task automatic lock_it(input bit t);
    erase_pfx(t);
    wr(t, 17'h05555, 8'h40);
  endtask

  task automatic test_reset;
    rchk(0, 17'h00000, 8'hFF, "R1 reset low byte");
    rchk(0, 17'h1FFFF, 8'hFF, "R1 reset high byte");
    rchk(1, 17'h0C005, 8'hFF, "R1 reset top-map byte");
  endtask

  task automatic test_program;
    prog(0, 17'h08003, 8'h5A);
    rchk(0, 17'h08003, 8'h5A, "R2 program erased byte");
    // unlock addresses with upper bits set still match on bits 14:0
    wr(0, 17'h15555, 8'hAA);
    wr(0, 17'h0AAAA, 8'h55);
    wr(0, 17'h1D555, 8'hA0);
    wr(0, 17'h08003, 8'h0F);
    repeat (PC + 1) @(negedge clk);
    rchk(0, 17'h08003, 8'h0A, "R2 reprogram ANDs data");
  endtask

  task automatic test_polling;
    prog_go(0, 17'h10001, 8'h80);
    rchk(0, 17'h10001, 8'h00, "R3 poll first busy cycle");
    repeat (PC - 1) @(negedge clk);
    rchk(0, 17'h10001, 8'h00, "R3 poll last busy cycle");
    @(negedge clk);
    rchk(0, 17'h10001, 8'h80, "R3 true data after program");
    prog_go(0, 17'h10002, 8'h35);
    rchk(0, 17'h08003, 8'h80, "R3 poll bit7 inverted any address");
    repeat (PC + 1) @(negedge clk);
    rchk(0, 17'h10002, 8'h35, "R3 second program done");
  endtask

  task automatic test_chip_erase;
    erase_pfx(0);
    wr(0, 17'h05555, 8'h10);
    rchk(0, 17'h10001, 8'h00, "R3 erase poll first cycle");
    repeat (EC - 1) @(negedge clk);
    rchk(0, 17'h10001, 8'h00, "R3 erase poll last cycle");
    @(negedge clk);
    rchk(0, 17'h10001, 8'hFF, "R4 chip erase main");
    rchk(0, 17'h08003, 8'hFF, "R4 chip erase second main");
  endtask

  task automatic test_sector;
    prog(0, 17'h04001, 8'h11);
    prog(0, 17'h06001, 8'h22);
    prog(0, 17'h02001, 8'h33);
    sect(0, 17'h05ABC);
    rchk(0, 17'h04001, 8'hFF, "R5 R6 target parameter sector erased");
    rchk(0, 17'h06001, 8'h22, "R5 R6 neighbour parameter sector kept");
    rchk(0, 17'h02001, 8'h33, "R5 R6 boot sector kept");
  endtask

  task automatic test_id;
    pfx(0);
    wr(0, 17'h05555, 8'h90);
    rchk(0, 17'h00000, MID, "R7 manufacturer byte");
    rchk(0, 17'h00001, DID, "R7 device byte");
    rchk(0, 17'h00002, 8'h00, "R7 R1 lock flag clear");
    wr(0, 17'h12345, 8'hF0);
    rchk(0, 17'h06001, 8'h22, "R7 exit returns array data");
  endtask

  task automatic test_broken;
    pfx(0);
    wr(0, 17'h05555, 8'h77);
    wr(0, 17'h06001, 8'h00);
    rchk(0, 17'h06001, 8'h22, "R9 bad third write");
    wr(0, 17'h05555, 8'hAA);
    wr(0, 17'h02AAA, 8'h12);
    wr(0, 17'h05555, 8'hA0);
    wr(0, 17'h06001, 8'h00);
    rchk(0, 17'h06001, 8'h22, "R9 bad second write");
  endtask

  task automatic test_busy_ignore;
    prog_go(0, 17'h06002, 8'h7E);
    prog_go(0, 17'h06003, 8'h00);
    repeat (PC + 1) @(negedge clk);
    rchk(0, 17'h06002, 8'h7E, "R10 running program completes");
    rchk(0, 17'h06003, 8'hFF, "R10 writes during busy ignored");
  endtask

  task automatic test_lock;
    lock_it(0);
    pfx(0);
    wr(0, 17'h05555, 8'h90);
    rchk(0, 17'h00002, 8'h01, "R8 lock flag set");
    wr(0, 17'h00000, 8'hF0);
    prog_go(0, 17'h02001, 8'h00);
    rchk(0, 17'h02001, 8'h33, "R8 boot program dropped no busy");
    sect(0, 17'h01000);
    rchk(0, 17'h02001, 8'h33, "R8 boot sector erase dropped");
    chip(0);
    rchk(0, 17'h02001, 8'h33, "R8 R4 chip erase spares boot");
    rchk(0, 17'h06001, 8'hFF, "R8 R4 chip erase other sectors");
    prog(0, 17'h10005, 8'h44);
    rchk(0, 17'h10005, 8'h44, "R8 main program still works");
  endtask

  task automatic test_top_map;
    prog(1, 17'h1C002, 8'h55);
    prog(1, 17'h18002, 8'h66);
    prog(1, 17'h1A002, 8'h77);
    prog(1, 17'h00002, 8'h12);
    sect(1, 17'h19FFF);
    rchk(1, 17'h18002, 8'hFF, "R6 top map far parameter erased");
    rchk(1, 17'h1A002, 8'h77, "R6 top map near parameter kept");
    rchk(1, 17'h1C002, 8'h55, "R6 top map boot kept");
    rchk(1, 17'h00002, 8'h12, "R6 top map low main kept");
    lock_it(1);
    prog(1, 17'h1C002, 8'h00);
    rchk(1, 17'h1C002, 8'h55, "R6 R8 top boot locked");
    prog(1, 17'h00004, 8'h21);
    rchk(1, 17'h00004, 8'h21, "R6 R8 low address writable in top map");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_program();
    test_polling();
    test_chip_erase();
    test_sector();
    test_id();
    test_broken();
    test_busy_ignore();
    test_lock();
    test_top_map();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule